// File: doc/BRIEF.md
# Live-Value-Table Multiported Register File

This block is a register file with several independent read ports and several independent write ports. It is built only from simple storage banks that each offer one combinational read port and one clocked write port. Every write port owns a private group of banks, and that group holds one copy per read port, so no read port ever shares a bank with another.

A small flip-flop table tracks, for each register, which write port most recently stored its value. Each read port looks up its address in this table and steers its output to the copy held by that write port. When two or more write ports target the same register in one cycle, the lowest-numbered port wins. A flush or hold input cancels every write in the cycle. The file has no internal bypass: a read in the cycle of a write returns the previous contents, and forwarding is left to the surrounding pipeline. Register count, data width and both port counts are parameters. The default is 64 registers of 64 bits with six read and three write ports.

Top module: `lvt_regfile`

## Requirements
- R1: After reset every register reads as zero on every read port.
- R2: Each read port returns, in the same cycle and independently of the other read ports, the stored value of the register at its address.
- R3: A write that takes effect at a clock edge is visible on every read port from the cycle after that edge.
- R4: A read of a register that is being written in the same cycle returns the value held before that write.
- R5: When several write ports with their enables high target one register in the same cycle, only the lowest-numbered of them updates it. The writes of the other ports in that cycle have no effect.
- R6: While flush is high, no write port changes any register.
- R7: While hold is high, no write port changes any register.
- R8: Write ports that target distinct registers in the same cycle all take effect.
- R9: The newest write to a register determines its value, whichever write port made it, including when successive writes come from different ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| hold | input | 1 | Blocks all updates in the cycle |
| flush | input | 1 | Cancels all writes in the cycle |
| wrEn | input | NUM_WR | Write enable, one bit per write port |
| wrAddr | input | NUM_WR x clog2(NUM_REGS) | Target register per write port |
| wrData | input | NUM_WR x DATA_W | Write value per write port |
| rdAddr | input | NUM_RD x clog2(NUM_REGS) | Register address per read port |
| rdData | output | NUM_RD x DATA_W | Read value per read port, combinational |

## Verification
On every cycle, the assertions check that flush and hold leave every bank write strobe low, and that a port losing an address conflict to a lower port issues no bank write. They also check that an accepted write reaches every read port one cycle later, and that read data stays put when no write happens and the addresses do not change. Only the bench's scenarios can show that reset clears the whole file, that the table steers reads correctly after a register has moved between ports, and that a read in the cycle of a write still returns the old contents. For these the bench compares every read port against a reference array, first in directed sequences and then under random multi-port traffic on a small configuration.

// File: rtl/lvtrf_pkg.sv
package lvtrf_pkg;

  // Width of a field naming one of n items, never below one bit.
  function automatic int selWidth(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/lvt_bank.sv
// One storage copy: combinational read, clocked write, cleared on reset.
module lvt_bank #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 64,
  localparam int AW = lvtrf_pkg::selWidth(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             we,
  input  logic [AW-1:0]    wAddr,
  input  logic [WIDTH-1:0] wData,
  input  logic [AW-1:0]    rAddr,
  output logic [WIDTH-1:0] rData
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wAddr] <= wData;
    end
  end

  assign rData = mem[rAddr];

endmodule

// File: rtl/lvt_ctrl.sv
// Control: resolves write conflicts, gates writes with flush and hold,
// keeps the live-value table and produces a bank select per read port.
module lvt_ctrl #(
  parameter int NUM_REGS = 64,
  parameter int NUM_RD   = 6,
  parameter int NUM_WR   = 3,
  localparam int AW   = lvtrf_pkg::selWidth(NUM_REGS),
  localparam int SELW = lvtrf_pkg::selWidth(NUM_WR)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         hold,
  input  logic                         flush,
  input  logic [NUM_WR-1:0]            wrEn,
  input  logic [NUM_WR-1:0][AW-1:0]    wrAddr,
  input  logic [NUM_RD-1:0][AW-1:0]    rdAddr,
  output logic [NUM_WR-1:0]            bankWe,
  output logic [NUM_RD-1:0][SELW-1:0]  rdSel
);

  logic [SELW-1:0] liveTbl [NUM_REGS];
  logic            gateOpen;

  assign gateOpen = !flush && !hold;

  // A port writes only if no lower-numbered enabled port hits the same register.
  always_comb begin
    for (int w = 0; w < NUM_WR; w++) begin
      bankWe[w] = wrEn[w] && gateOpen;
      for (int v = 0; v < w; v++) begin
        if (wrEn[v] && (wrAddr[v] == wrAddr[w])) bankWe[w] = 1'b0;
      end
    end
  end

  // Winners always have distinct addresses, so update order does not matter.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) liveTbl[i] <= '0;
    end else begin
      for (int w = 0; w < NUM_WR; w++) begin
        if (bankWe[w]) liveTbl[wrAddr[w]] <= SELW'(w);
      end
    end
  end

  always_comb begin
    for (int r = 0; r < NUM_RD; r++) rdSel[r] = liveTbl[rdAddr[r]];
  end

endmodule

// File: rtl/lvt_datapath.sv
// Datapath: NUM_WR x NUM_RD banks and the per-read-port output steering.
module lvt_datapath #(
  parameter int NUM_REGS = 64,
  parameter int DATA_W   = 64,
  parameter int NUM_RD   = 6,
  parameter int NUM_WR   = 3,
  localparam int AW   = lvtrf_pkg::selWidth(NUM_REGS),
  localparam int SELW = lvtrf_pkg::selWidth(NUM_WR)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_WR-1:0]              bankWe,
  input  logic [NUM_WR-1:0][AW-1:0]      wrAddr,
  input  logic [NUM_WR-1:0][DATA_W-1:0]  wrData,
  input  logic [NUM_RD-1:0][AW-1:0]      rdAddr,
  input  logic [NUM_RD-1:0][SELW-1:0]    rdSel,
  output logic [NUM_RD-1:0][DATA_W-1:0]  rdData
);

  logic [NUM_WR-1:0][NUM_RD-1:0][DATA_W-1:0] bankRd;

  for (genvar w = 0; w < NUM_WR; w++) begin : g_wr
    for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
      lvt_bank #(
        .DEPTH (NUM_REGS),
        .WIDTH (DATA_W)
      ) u_bank (
        .clk   (clk),
        .rstN  (rstN),
        .we    (bankWe[w]),
        .wAddr (wrAddr[w]),
        .wData (wrData[w]),
        .rAddr (rdAddr[r]),
        .rData (bankRd[w][r])
      );
    end
  end

  always_comb begin
    for (int r = 0; r < NUM_RD; r++) begin
      rdData[r] = '0;
      for (int w = 0; w < NUM_WR; w++) begin
        if (int'(rdSel[r]) == w) rdData[r] = bankRd[w][r];
      end
    end
  end

endmodule

// File: rtl/lvt_regfile.sv
// Thin top: wires control and datapath together.
module lvt_regfile #(
  parameter int NUM_REGS = 64,
  parameter int DATA_W   = 64,
  parameter int NUM_RD   = 6,
  parameter int NUM_WR   = 3,
  localparam int AW   = lvtrf_pkg::selWidth(NUM_REGS),
  localparam int SELW = lvtrf_pkg::selWidth(NUM_WR)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           hold,
  input  logic                           flush,
  input  logic [NUM_WR-1:0]              wrEn,
  input  logic [NUM_WR-1:0][AW-1:0]      wrAddr,
  input  logic [NUM_WR-1:0][DATA_W-1:0]  wrData,
  input  logic [NUM_RD-1:0][AW-1:0]      rdAddr,
  output logic [NUM_RD-1:0][DATA_W-1:0]  rdData
);

  logic [NUM_WR-1:0]           bankWe;
  logic [NUM_RD-1:0][SELW-1:0] rdSel;

  lvt_ctrl #(
    .NUM_REGS (NUM_REGS),
    .NUM_RD   (NUM_RD),
    .NUM_WR   (NUM_WR)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .hold   (hold),
    .flush  (flush),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr),
    .bankWe (bankWe),
    .rdSel  (rdSel)
  );

  lvt_datapath #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .NUM_RD   (NUM_RD),
    .NUM_WR   (NUM_WR)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .bankWe (bankWe),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .rdSel  (rdSel),
    .rdData (rdData)
  );

endmodule

// File: rtl/lvt_regfile_chk.sv
module lvt_regfile_chk #(
  parameter int NUM_REGS = 64,
  parameter int DATA_W   = 64,
  parameter int NUM_RD   = 6,
  parameter int NUM_WR   = 3,
  localparam int AW = lvtrf_pkg::selWidth(NUM_REGS)
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           hold,
  input logic                           flush,
  input logic [NUM_WR-1:0]              wrEn,
  input logic [NUM_WR-1:0][AW-1:0]      wrAddr,
  input logic [NUM_WR-1:0][DATA_W-1:0]  wrData,
  input logic [NUM_RD-1:0][AW-1:0]      rdAddr,
  input logic [NUM_RD-1:0][DATA_W-1:0]  rdData,
  input logic [NUM_WR-1:0]              bankWe
);

  // R6: flush cancels every bank write strobe.
  a_r6_flush_blocks: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> (bankWe == '0));

  // R7: hold cancels every bank write strobe.
  a_r7_hold_blocks: assert property (@(posedge clk) disable iff (!rstN)
    hold |-> (bankWe == '0));

  // R2: with no write and steady addresses, read data does not move.
  a_r2_steady_read: assert property (@(posedge clk) disable iff (!rstN)
    (bankWe == '0) |=> (!$stable(rdAddr) || $stable(rdData)));

  for (genvar w = 1; w < NUM_WR; w++) begin : g_prio
    for (genvar v = 0; v < w; v++) begin : g_low
      // R5: a lower enabled port on the same register suppresses port w.
      a_r5_low_port_wins: assert property (@(posedge clk) disable iff (!rstN)
        (wrEn[v] && (wrAddr[v] == wrAddr[w])) |-> !bankWe[w]);
    end
  end

  for (genvar w = 0; w < NUM_WR; w++) begin : g_vis
    for (genvar r = 0; r < NUM_RD; r++) begin : g_rp
      // R3: an accepted write appears on every read port one cycle later.
      a_r3_write_visible: assert property (@(posedge clk) disable iff (!rstN)
        bankWe[w] |=> ((rdAddr[r] != $past(wrAddr[w])) ||
                       (rdData[r] == $past(wrData[w]))));
    end
  end

endmodule

bind lvt_regfile lvt_regfile_chk #(
  .NUM_REGS (NUM_REGS),
  .DATA_W   (DATA_W),
  .NUM_RD   (NUM_RD),
  .NUM_WR   (NUM_WR)
) u_chk (.*);

// File: tb/lvt_regfile_tb.sv
module lvt_regfile_tb;

  localparam int NREGS = 8;
  localparam int DW    = 16;
  localparam int NRD   = 3;
  localparam int NWR   = 3;
  localparam int AW    = $clog2(NREGS);

  logic clk = 1'b0;
  logic rstN;
  logic hold, flush;
  logic [NWR-1:0]          wrEn;
  logic [NWR-1:0][AW-1:0]  wrAddr;
  logic [NWR-1:0][DW-1:0]  wrData;
  logic [NRD-1:0][AW-1:0]  rdAddr;
  logic [NRD-1:0][DW-1:0]  rdData;

  logic [DW-1:0] refMem [NREGS];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  lvt_regfile #(
    .NUM_REGS (NREGS),
    .DATA_W   (DW),
    .NUM_RD   (NRD),
    .NUM_WR   (NWR)
  ) u_dut (
    .clk    (clk),
    .rstN   (rstN),
    .hold   (hold),
    .flush  (flush),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .rdData (rdData)
  );

  // Compare every read port with the reference, then apply the edge.
  task automatic step(input string tag);
    #1;
    for (int r = 0; r < NRD; r++) begin
      checks++;
      if (rdData[r] !== refMem[rdAddr[r]]) begin
        fails++;
        $display("FAIL %s read port %0d addr %0d: actual %h expected %h",
                 tag, r, rdAddr[r], rdData[r], refMem[rdAddr[r]]);
      end
    end
    @(posedge clk);
    // Reference: highest port first so the lowest-numbered port lands last.
    if (!flush && !hold) begin
      for (int w = NWR - 1; w >= 0; w--) begin
        if (wrEn[w]) refMem[wrAddr[w]] = wrData[w];
      end
    end
    @(negedge clk);
    wrEn = '0; flush = 1'b0; hold = 1'b0;
  endtask

  task automatic setWr(input int p, input int a, input logic [DW-1:0] d);
    wrEn[p] = 1'b1;
    wrAddr[p] = AW'(a);
    wrData[p] = d;
  endtask

  task automatic setRd(input int a0, input int a1, input int a2);
    rdAddr[0] = AW'(a0); rdAddr[1] = AW'(a1); rdAddr[2] = AW'(a2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREGS; i++) refMem[i] = '0;
    rstN = 1'b0; hold = 1'b0; flush = 1'b0;
    wrEn = '0; wrAddr = '0; wrData = '0; rdAddr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: whole file zero after reset, swept over all ports.
    for (int a = 0; a < NREGS; a++) begin
      setRd(a, (a + 3) % NREGS, (a + 5) % NREGS);
      step("R1");
    end

    // R8: three distinct registers written at once.
    setWr(0, 1, 16'h1111); setWr(1, 2, 16'h2222); setWr(2, 3, 16'h3333);
    setRd(0, 0, 0);
    step("R8");
    setRd(1, 2, 3); step("R8");
    setRd(3, 1, 2); step("R2");

    // R5: all ports on one register, port 0 wins.
    setWr(0, 4, 16'hAAAA); setWr(1, 4, 16'hBBBB); setWr(2, 4, 16'hCCCC);
    step("R5");
    setRd(4, 4, 4); step("R5");
    // R5: ports 1 and 2 collide, port 1 wins, port 0 elsewhere.
    setWr(0, 6, 16'h0606); setWr(1, 5, 16'h5151); setWr(2, 5, 16'h5252);
    step("R5");
    setRd(5, 6, 5); step("R5");

    // R9: one register moves between write ports.
    setWr(2, 7, 16'h7002); step("R9");
    setRd(7, 7, 7); step("R9");
    setWr(0, 7, 16'h7000); step("R9");
    step("R9");
    setWr(1, 7, 16'h7001); step("R9");
    step("R9");
    setWr(2, 7, 16'h7222); step("R9");
    step("R9");

    // R4: read during the write cycle sees the previous value.
    setRd(2, 3, 7);
    setWr(0, 2, 16'hD00D); setWr(1, 3, 16'hE00E); setWr(2, 7, 16'hF00F);
    step("R4");
    step("R3");

    // R6: flush cancels writes.
    setRd(1, 2, 3);
    flush = 1'b1;
    setWr(0, 1, 16'hBAD0); setWr(1, 2, 16'hBAD1); setWr(2, 3, 16'hBAD2);
    step("R6");
    step("R6");

    // R7: hold cancels writes.
    hold = 1'b1;
    setWr(0, 1, 16'hBAD3); setWr(1, 2, 16'hBAD4); setWr(2, 3, 16'hBAD5);
    step("R7");
    step("R7");

    // R3: random multi-port traffic with occasional flush and hold.
    for (int n = 0; n < 4000; n++) begin
      for (int p = 0; p < NWR; p++) begin
        if ($urandom_range(3) != 0)
          setWr(p, int'($urandom_range(NREGS - 1)), DW'($urandom));
      end
      for (int r = 0; r < NRD; r++) rdAddr[r] = AW'($urandom_range(NREGS - 1));
      flush = ($urandom_range(15) == 0);
      hold  = ($urandom_range(15) == 0);
      step("R3");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule